// File: doc/BRIEF.md
# Window Threshold Monitor with Selectable Sample Source

This block compares signed sample values against a programmable window formed by an upper and a lower limit. A sample above the upper limit sets a per-channel high flag. A sample below the lower limit sets a per-channel low flag. Each crossing can also raise an interrupt line and a one-cycle break pulse, which stops downstream logic quickly.

One comparator pair is shared between two kinds of data. In fast mode it watches a raw sample stream taken from the serial channel inputs. In standard mode it watches the final conversion results, which arrive on two streams: the injected group and the regular group. A channel mask selects which channel tags are watched, and samples on other channels are dropped.

All three sample inputs are valid/ready streams. The monitor never stalls the stream that is active: its `ready` follows only the mode bit and the injected-over-regular priority, and never depends on that stream's own `valid`. A beat is consumed when `valid && ready`. A source that sees `ready` low must hold its beat, because the beat is not consumed.

Top module: `win_thresh_mon`

## Requirements
- R1: Comparison is signed two's complement over DW bits. A consumed sample with data > upper limit is a high crossing, and one with data < lower limit is a low crossing. A sample equal to either limit is not a crossing.
- R2: When `cfg_fast_mode`=1, `fs_ready`=1 and `inj_ready`=`reg_ready`=0. When `cfg_fast_mode`=0, `fs_ready`=0 and the group streams are the candidates. A beat on a stream whose ready is low changes no flag and gives no break.
- R3: In standard mode the injected stream has priority. `inj_ready`=1, and `reg_ready`=1 only while `inj_valid`=0. When both are valid in the same cycle, only the injected beat is consumed.
- R4: A consumed beat whose channel tag n has `cfg_ch_mask[n]`=0 changes no flag and gives no break. Bit n of the mask is channel n.
- R5: `flag_hi[n]` and `flag_lo[n]` are set at the clock edge that consumes a crossing beat on channel n. They stay set until they are cleared.
- R6: Writing a one to `clr_hi[n]` or `clr_lo[n]` clears that flag at the next edge. If a set and a clear reach the same flag in the same cycle, the flag stays set.
- R7: `irq` = (`cfg_hi_ie` AND any `flag_hi` bit) OR (`cfg_lo_ie` AND any `flag_lo` bit).
- R8: With `cfg_brk_en`=1, every consumed, watched crossing makes `brk_pulse` high for exactly the cycle after the consuming edge. This holds even if the flag was already set. With `cfg_brk_en`=0, `brk_pulse` stays low.
- R9: After reset all flags, `irq` and `brk_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hi_thr | input | DW | Upper limit, signed |
| cfg_lo_thr | input | DW | Lower limit, signed |
| cfg_ch_mask | input | NCH | Watched-channel mask |
| cfg_fast_mode | input | 1 | 1: raw serial stream, 0: conversion results |
| cfg_hi_ie | input | 1 | Interrupt enable for high flags |
| cfg_lo_ie | input | 1 | Interrupt enable for low flags |
| cfg_brk_en | input | 1 | Break pulse enable |
| fs_valid | input | 1 | Raw stream beat valid |
| fs_ready | output | 1 | Raw stream ready |
| fs_chan | input | CHW | Raw stream channel tag |
| fs_data | input | DW | Raw stream sample |
| inj_valid | input | 1 | Injected result valid |
| inj_ready | output | 1 | Injected result ready |
| inj_chan | input | CHW | Injected result channel tag |
| inj_data | input | DW | Injected result value |
| reg_valid | input | 1 | Regular result valid |
| reg_ready | output | 1 | Regular result ready |
| reg_chan | input | CHW | Regular result channel tag |
| reg_data | input | DW | Regular result value |
| clr_hi | input | NCH | Write-one-to-clear for high flags |
| clr_lo | input | NCH | Write-one-to-clear for low flags |
| flag_hi | output | NCH | Sticky high flags per channel |
| flag_lo | output | NCH | Sticky low flags per channel |
| irq | output | 1 | Interrupt request |
| brk_pulse | output | 1 | One-cycle break event |

## Verification
The bench sweeps both modes, all three streams, both channels, every mask value and samples at each limit, one past each limit and at both extremes of the signed range. This catches an unsigned or non-strict comparison, which would flag the most negative value as high or flag a value equal to a limit. Directed cases look at a set and a clear in the same cycle, which a clear-wins design would lose. They also look at a repeated crossing on a flag that is already set, which a design that breaks only on flag edges would miss. Finally, they look at simultaneous injected and regular beats, where wrong priority would set the regular channel's flag.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_INJ  = 2'd2,
    SRC_REG  = 2'd3
  } wtm_src_e;
endpackage

// File: rtl/wtm_src_sel.sv
module wtm_src_sel
  import wtm_pkg::*;
#(
  parameter int DW  = 24,
  parameter int CHW = 1
) (
  input  logic           fast_mode,
  input  logic           fs_valid,
  input  logic [CHW-1:0] fs_chan,
  input  logic [DW-1:0]  fs_data,
  input  logic           inj_valid,
  input  logic [CHW-1:0] inj_chan,
  input  logic [DW-1:0]  inj_data,
  input  logic           reg_valid,
  input  logic [CHW-1:0] reg_chan,
  input  logic [DW-1:0]  reg_data,
  output logic           fs_ready,
  output logic           inj_ready,
  output logic           reg_ready,
  output logic           sel_valid,
  output logic [CHW-1:0] sel_chan,
  output logic [DW-1:0]  sel_data,
  output wtm_src_e       sel_src
);
  // ready depends on mode and on the higher-priority stream, never on own valid
  assign fs_ready  = fast_mode;
  assign inj_ready = !fast_mode;
  assign reg_ready = !fast_mode && !inj_valid;

  always_comb begin
    sel_src  = SRC_NONE;
    sel_chan = '0;
    sel_data = '0;
    if (fs_valid && fs_ready) begin
      sel_src  = SRC_FAST;
      sel_chan = fs_chan;
      sel_data = fs_data;
    end else if (inj_valid && inj_ready) begin
      sel_src  = SRC_INJ;
      sel_chan = inj_chan;
      sel_data = inj_data;
    end else if (reg_valid && reg_ready) begin
      sel_src  = SRC_REG;
      sel_chan = reg_chan;
      sel_data = reg_data;
    end
  end

  assign sel_valid = (sel_src != SRC_NONE);
endmodule

// File: rtl/wtm_cmp.sv
module wtm_cmp #(
  parameter int DW = 24
) (
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] hi_thr,
  input  logic [DW-1:0] lo_thr,
  output logic          above,
  output logic          below
);
  assign above = valid && ($signed(data) > $signed(hi_thr));
  assign below = valid && ($signed(data) < $signed(lo_thr));
endmodule

// File: rtl/wtm_flags.sv
module wtm_flags #(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit_valid,
  input  logic [CHW-1:0] hit_chan,
  input  logic           hit_hi,
  input  logic           hit_lo,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] clr_hi,
  input  logic [NCH-1:0] clr_lo,
  output logic [NCH-1:0] flag_hi,
  output logic [NCH-1:0] flag_lo,
  output logic           watched_hit
);
  logic [NCH-1:0] ch_sel;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_sel[n] = hit_valid && (hit_chan == CHW'(n)) && mask[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_hi[n] <= 1'b0;
        flag_lo[n] <= 1'b0;
      end else begin
        // a set in the same cycle as a clear keeps the flag up
        flag_hi[n] <= (flag_hi[n] && !clr_hi[n]) || (ch_sel[n] && hit_hi);
        flag_lo[n] <= (flag_lo[n] && !clr_lo[n]) || (ch_sel[n] && hit_lo);
      end
    end
  end

  assign watched_hit = (|ch_sel) && (hit_hi || hit_lo);
endmodule

// File: rtl/win_thresh_mon.sv
module win_thresh_mon
  import wtm_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  cfg_hi_thr,
  input  logic [DW-1:0]  cfg_lo_thr,
  input  logic [NCH-1:0] cfg_ch_mask,
  input  logic           cfg_fast_mode,
  input  logic           cfg_hi_ie,
  input  logic           cfg_lo_ie,
  input  logic           cfg_brk_en,
  input  logic           fs_valid,
  output logic           fs_ready,
  input  logic [CHW-1:0] fs_chan,
  input  logic [DW-1:0]  fs_data,
  input  logic           inj_valid,
  output logic           inj_ready,
  input  logic [CHW-1:0] inj_chan,
  input  logic [DW-1:0]  inj_data,
  input  logic           reg_valid,
  output logic           reg_ready,
  input  logic [CHW-1:0] reg_chan,
  input  logic [DW-1:0]  reg_data,
  input  logic [NCH-1:0] clr_hi,
  input  logic [NCH-1:0] clr_lo,
  output logic [NCH-1:0] flag_hi,
  output logic [NCH-1:0] flag_lo,
  output logic           irq,
  output logic           brk_pulse
);
  logic           sel_valid;
  logic [CHW-1:0] sel_chan;
  logic [DW-1:0]  sel_data;
  wtm_src_e       sel_src;
  logic           above, below, watched_hit;

  wtm_src_sel #(.DW(DW), .CHW(CHW)) u_sel (
    .fast_mode (cfg_fast_mode),
    .fs_valid  (fs_valid),  .fs_chan  (fs_chan),  .fs_data  (fs_data),
    .inj_valid (inj_valid), .inj_chan (inj_chan), .inj_data (inj_data),
    .reg_valid (reg_valid), .reg_chan (reg_chan), .reg_data (reg_data),
    .fs_ready  (fs_ready),  .inj_ready (inj_ready), .reg_ready (reg_ready),
    .sel_valid (sel_valid), .sel_chan (sel_chan), .sel_data (sel_data),
    .sel_src   (sel_src)
  );

  wtm_cmp #(.DW(DW)) u_cmp (
    .valid  (sel_valid),
    .data   (sel_data),
    .hi_thr (cfg_hi_thr),
    .lo_thr (cfg_lo_thr),
    .above  (above),
    .below  (below)
  );

  wtm_flags #(.NCH(NCH), .CHW(CHW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_valid   (sel_valid),
    .hit_chan    (sel_chan),
    .hit_hi      (above),
    .hit_lo      (below),
    .mask        (cfg_ch_mask),
    .clr_hi      (clr_hi),
    .clr_lo      (clr_lo),
    .flag_hi     (flag_hi),
    .flag_lo     (flag_lo),
    .watched_hit (watched_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= cfg_brk_en && watched_hit;
  end

  assign irq = (cfg_hi_ie && (|flag_hi)) || (cfg_lo_ie && (|flag_lo));

  logic unused_src;
  assign unused_src = ^sel_src;
endmodule

// File: rtl/wtm_chk.sv
module wtm_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_fast_mode,
  input logic           cfg_brk_en,
  input logic           fs_valid,
  input logic           inj_valid,
  input logic           reg_valid,
  input logic           fs_ready,
  input logic           inj_ready,
  input logic           reg_ready,
  input logic [NCH-1:0] clr_hi,
  input logic [NCH-1:0] clr_lo,
  input logic [NCH-1:0] flag_hi,
  input logic [NCH-1:0] flag_lo,
  input logic           brk_pulse
);
  // R2: only one source class is ever ready
  a_r2_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_ready && (inj_ready || reg_ready)));

  // R3: regular results wait while an injected result is offered
  a_r3_inj_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fast_mode && inj_valid) |-> !reg_ready);

  // R2: no consumable beat -> no new flag and no break
  a_r2_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    !((fs_valid && fs_ready) || (inj_valid && inj_ready) || (reg_valid && reg_ready))
    |=> (((flag_hi & ~$past(flag_hi)) == '0) && ((flag_lo & ~$past(flag_lo)) == '0) && !brk_pulse));

  // R5/R6: an uncleared flag holds
  a_r5_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_hi & $past(flag_hi & ~clr_hi)) == $past(flag_hi & ~clr_hi)));
  a_r5_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_lo & $past(flag_lo & ~clr_lo)) == $past(flag_lo & ~clr_lo)));

  // R8: break needs its enable and is backed by a raised flag
  a_r8_brk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_brk_en |=> !brk_pulse);
  a_r8_brk_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> ((flag_hi | flag_lo) != '0));
endmodule

bind win_thresh_mon wtm_chk #(.NCH(NCH)) u_chk (
  .clk (clk), .rst_n (rst_n), .cfg_fast_mode (cfg_fast_mode), .cfg_brk_en (cfg_brk_en),
  .fs_valid (fs_valid), .inj_valid (inj_valid), .reg_valid (reg_valid),
  .fs_ready (fs_ready), .inj_ready (inj_ready), .reg_ready (reg_ready),
  .clr_hi (clr_hi), .clr_lo (clr_lo), .flag_hi (flag_hi), .flag_lo (flag_lo),
  .brk_pulse (brk_pulse)
);

// File: tb/win_thresh_mon_tb.sv
module win_thresh_mon_tb;
  localparam int DW = 24;
  localparam int NCH = 2;
  localparam int HI = 100;
  localparam int LO = -100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] cfg_hi_thr, cfg_lo_thr;
  logic [NCH-1:0] cfg_ch_mask;
  logic cfg_fast_mode, cfg_hi_ie, cfg_lo_ie, cfg_brk_en;
  logic fs_valid, inj_valid, reg_valid;
  logic fs_ready, inj_ready, reg_ready;
  logic [0:0] fs_chan, inj_chan, reg_chan;
  logic [DW-1:0] fs_data, inj_data, reg_data;
  logic [NCH-1:0] clr_hi, clr_lo, flag_hi, flag_lo;
  logic irq, brk_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  win_thresh_mon #(.DW(DW), .NCH(NCH)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    fs_valid = 0; inj_valid = 0; reg_valid = 0;
    clr_hi = '0; clr_lo = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    idle();
    clr_hi = '1; clr_lo = '1;
    @(negedge clk);
    idle();
  endtask

  // path 0 raw, 1 injected, 2 regular; beat held one cycle
  task automatic drive(input int path, input int ch, input int val);
    case (path)
      0: begin fs_valid = 1; fs_chan = 1'(ch); fs_data = DW'(val); end
      1: begin inj_valid = 1; inj_chan = 1'(ch); inj_data = DW'(val); end
      default: begin reg_valid = 1; reg_chan = 1'(ch); reg_data = DW'(val); end
    endcase
  endtask

  int vals[8];

  initial begin
    vals = '{-(1 << 23), LO - 1, LO, 0, HI, HI + 1, (1 << 23) - 1, -5};
    cfg_hi_thr = DW'(HI); cfg_lo_thr = DW'(LO);
    cfg_ch_mask = '1; cfg_fast_mode = 1; cfg_hi_ie = 1; cfg_lo_ie = 1; cfg_brk_en = 1;
    fs_chan = 0; inj_chan = 0; reg_chan = 0; fs_data = 0; inj_data = 0; reg_data = 0;
    idle();
    repeat (3) @(negedge clk);
    chk("R9 flag_hi", int'(flag_hi), 0);
    chk("R9 flag_lo", int'(flag_lo), 0);
    chk("R9 irq", int'(irq), 0);
    chk("R9 brk", int'(brk_pulse), 0);
    rst_n = 1;

    // sweep
    for (int k = 0; k < 2 * 3 * 2 * 4 * 8; k++) begin
      automatic int vi = k % 8;
      automatic int msk = (k / 8) % 4;
      automatic int ch = (k / 32) % 2;
      automatic int path = (k / 64) % 3;
      automatic int fm = (k / 192) % 2;
      automatic int v = vals[vi];
      automatic bit acc, hi, lo, ehi, elo, en_hi, en_lo, en_b;
      en_hi = k[0]; en_lo = k[1] ^ k[3]; en_b = !k[2] || k[4];
      cfg_fast_mode = fm[0]; cfg_ch_mask = 2'(msk);
      cfg_hi_ie = en_hi; cfg_lo_ie = en_lo; cfg_brk_en = en_b;
      clear_all();
      drive(path, ch, v);
      #1;
      chk("R2 fs_ready", int'(fs_ready), fm);
      chk("R2 inj_ready", int'(inj_ready), int'(fm == 0));
      acc = ((path == 0) == (fm == 1)) && msk[ch];
      hi = v > HI; lo = v < LO;
      ehi = acc && hi; elo = acc && lo;
      @(negedge clk);
      idle();
      chk("R1 R4 R5 flag_hi", int'(flag_hi), ehi ? (1 << ch) : 0);
      chk("R1 R4 R5 flag_lo", int'(flag_lo), elo ? (1 << ch) : 0);
      chk("R7 irq", int'(irq), int'((en_hi && ehi) || (en_lo && elo)));
      chk("R8 brk", int'(brk_pulse), int'(en_b && (ehi || elo)));
      @(negedge clk);
      chk("R8 brk one cycle", int'(brk_pulse), 0);
      chk("R5 flag held", int'(flag_hi | flag_lo), (ehi || elo) ? (1 << ch) : 0);
    end

    // R6 clear, and set+clear same cycle
    cfg_fast_mode = 1; cfg_ch_mask = '1; cfg_brk_en = 1; cfg_hi_ie = 1; cfg_lo_ie = 1;
    clear_all();
    drive(0, 1, 500);
    @(negedge clk); idle();
    chk("R5 set ch1", int'(flag_hi), 2);
    drive(0, 1, 600); clr_hi = 2'b10;
    @(negedge clk); idle();
    chk("R6 set wins", int'(flag_hi), 2);
    chk("R8 repeat crossing brk", int'(brk_pulse), 1);
    clr_hi = 2'b10;
    @(negedge clk); idle();
    chk("R6 cleared", int'(flag_hi), 0);
    chk("R7 irq low", int'(irq), 0);

    // R3 priority
    cfg_fast_mode = 0;
    clear_all();
    drive(1, 0, 300); drive(2, 1, -300);
    #1;
    chk("R3 reg_ready low", int'(reg_ready), 0);
    @(negedge clk); idle();
    chk("R3 inj taken", int'(flag_hi), 1);
    chk("R3 reg dropped", int'(flag_lo), 0);
    drive(2, 1, -300);
    #1;
    chk("R3 reg_ready high", int'(reg_ready), 1);
    @(negedge clk); idle();
    chk("R3 reg later", int'(flag_lo), 2);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule